// File: doc/BRIEF.md
# Block Write Protection Controller

This block holds the protection and enable state of a serial non-volatile memory and rules on every write request before it reaches the array or the status byte. A command decoder upstream turns serial opcodes into single-cycle strobes: set the write-enable latch, clear it, write the status byte (with its data), and write the array (with a byte address). The block answers each array write with a one-cycle grant or deny pulse. It answers each status write with a deny pulse when the request is refused, or with a grant pulse once chip select goes high and the internal write cycle may begin.

Three mechanisms decide the result. The write-enable latch must be set, and no write may be in progress. The two block-protect bits fence off nothing, the upper quarter, the upper half or the whole address space. The active-low write-protect pin can freeze the status byte, but only while the stored hardware-lock enable bit is 1. A status write that has been accepted waits for chip select to rise. If the pin drops before that, the write is cancelled. Once chip select has risen, the pin no longer affects that write. The status byte is always available for readback.

Top module: `bwp_ctrl`

## Requirements
- R1: The block-protect field sits in status bits 3:2 (bit 3 high). With 00 no address is protected. With 01 addresses whose two top bits are 11 (0x3000–0x3FFF for 14 bits) are protected. With 10 addresses whose top bit is 1 (0x2000–0x3FFF) are protected. With 11 every address is protected. An array write to a protected address is denied.
- R2: The write-enable latch (status bit 1) is set by the enable strobe and cleared by the disable strobe. Any array or status write made while the latch is 0 is denied.
- R3: An accepted status write raises `sr_grant` for one cycle in the cycle after `cs_n` is sampled high. In that same cycle the lock-enable bit (status bit 7) and block-protect bits (3:2) take the written data.
- R4: When the lock-enable bit is 1 and `wp_n` is 0 at the status write strobe, `sr_deny` pulses in the next cycle and the status byte is unchanged.
- R5: If `wp_n` is sampled 0 while an accepted status write is waiting with `cs_n` low and the lock-enable bit is 1, `sr_deny` pulses the next cycle and the status byte keeps its value. If `cs_n` is already sampled high, `wp_n` has no effect and the write is granted.
- R6: While the lock-enable bit is 0, `wp_n` is ignored and status writes follow R2 and R7 alone.
- R7: While `busy` is 1, every array or status write is denied. Status bit 0 shows `busy` in the same cycle. A `wr_done` pulse clears the write-enable latch.
- R8: Status bits 6:4 always read 0. After reset the status byte is 0x00 apart from bit 0, which follows `busy`.
- R9: Every array write strobe yields exactly one of `array_grant` or `array_deny` in the next cycle, and never both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| wp_n | input | 1 | Write-protect pin, active low |
| busy | input | 1 | Internal write cycle in progress |
| wr_done | input | 1 | Pulse: an internal write cycle completed |
| cmd_wren | input | 1 | Strobe: set write-enable latch |
| cmd_wrdi | input | 1 | Strobe: clear write-enable latch |
| cmd_wrsr | input | 1 | Strobe: write status byte |
| sr_wdata | input | 8 | Data for the status write |
| cmd_write | input | 1 | Strobe: array write request |
| wr_addr | input | ADDR_W | Byte address of the array write |
| array_grant | output | 1 | Array write permitted (one-cycle pulse) |
| array_deny | output | 1 | Array write refused (one-cycle pulse) |
| sr_grant | output | 1 | Status write committed (one-cycle pulse) |
| sr_deny | output | 1 | Status write refused or cancelled (one-cycle pulse) |
| status | output | 8 | Status byte for readback |

## Verification
Array grant and deny pulses, status-write refusals at the strobe, and latch changes all appear one cycle after the strobe is sampled. A status grant, or a cancellation by the pin, appears one cycle after the `cs_n` or `wp_n` level that causes it is sampled. `status[0]` follows `busy` with no delay. The bench changes inputs just after a falling clock edge. Each scenario task then waits for the next falling edge, so exactly one rising edge has passed before it reads the outputs. Cancellation and post-commit cases move `wp_n` and `cs_n` on their own negedge, so the cycle that decides is known.

// File: rtl/bwp_pkg.sv
package bwp_pkg;

    localparam int unsigned STATUS_W = 8;
    localparam int unsigned BIT_LOCK = 7;
    localparam int unsigned BIT_BP_HI = 3;
    localparam int unsigned BIT_BP_LO = 2;
    localparam int unsigned BIT_WEL = 1;
    localparam int unsigned BIT_BUSY = 0;

    typedef enum logic [1:0] {
        FENCE_NONE    = 2'b00,
        FENCE_QUARTER = 2'b01,
        FENCE_HALF    = 2'b10,
        FENCE_ALL     = 2'b11
    } fence_t;

    typedef struct packed {
        logic   lock_en;
        fence_t fence;
    } prot_fields_t;

    typedef enum logic {
        SRW_IDLE = 1'b0,
        SRW_WAIT = 1'b1
    } srw_state_t;

endpackage

// File: rtl/bwp_range.sv
module bwp_range
    import bwp_pkg::*;
#(
    parameter int unsigned ADDR_W = 14
) (
    input  fence_t            fence,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int unsigned TOP = ADDR_W - 1;

    always_comb begin
        unique case (fence)
            FENCE_NONE:    hit = 1'b0;
            FENCE_QUARTER: hit = addr[TOP] & addr[TOP-1];
            FENCE_HALF:    hit = addr[TOP];
            FENCE_ALL:     hit = 1'b1;
            default:       hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/bwp_wel.sv
module bwp_wel (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic done_i,
    output logic wel_o
);
    typedef struct packed {
        logic wel;
    } wel_st_t;

    wel_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (done_i || clr_i) begin
            st_d.wel = 1'b0;
        end else if (set_i) begin
            st_d.wel = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wel_o = st_q.wel;
endmodule

// File: rtl/bwp_srw.sv
module bwp_srw
    import bwp_pkg::*;
#(
    parameter int unsigned DATA_W = STATUS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              cs_n,
    input  logic              wp_n,
    input  logic              busy,
    input  logic              wel,
    output prot_fields_t      fields_o,
    output logic              grant_o,
    output logic              deny_o,
    output logic              waiting_o
);
    typedef struct packed {
        srw_state_t   state;
        prot_fields_t cur;
        prot_fields_t staged;
        logic         grant;
        logic         deny;
    } srw_st_t;

    srw_st_t st_d, st_q;
    logic    pin_locked;
    prot_fields_t incoming;

    assign pin_locked = st_q.cur.lock_en & ~wp_n;
    assign incoming   = '{lock_en: data_i[BIT_LOCK],
                          fence:   fence_t'(data_i[BIT_BP_HI:BIT_BP_LO])};

    always_comb begin
        st_d       = st_q;
        st_d.grant = 1'b0;
        st_d.deny  = 1'b0;
        unique case (st_q.state)
            SRW_IDLE: begin
                if (cmd_i) begin
                    if (busy || !wel || pin_locked) begin
                        st_d.deny = 1'b1;
                    end else begin
                        st_d.staged = incoming;
                        st_d.state  = SRW_WAIT;
                    end
                end
            end
            SRW_WAIT: begin
                if (cs_n) begin
                    st_d.cur   = st_q.staged;
                    st_d.grant = 1'b1;
                    st_d.state = SRW_IDLE;
                end else if (pin_locked) begin
                    st_d.deny  = 1'b1;
                    st_d.state = SRW_IDLE;
                end
            end
            default: st_d.state = SRW_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: SRW_IDLE, cur: '0, staged: '0,
                      grant: 1'b0, deny: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign fields_o  = st_q.cur;
    assign grant_o   = st_q.grant;
    assign deny_o    = st_q.deny;
    assign waiting_o = (st_q.state == SRW_WAIT);
endmodule

// File: rtl/bwp_ctrl.sv
module bwp_ctrl
    import bwp_pkg::*;
#(
    parameter int unsigned ADDR_W = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                wp_n,
    input  logic                busy,
    input  logic                wr_done,
    input  logic                cmd_wren,
    input  logic                cmd_wrdi,
    input  logic                cmd_wrsr,
    input  logic [STATUS_W-1:0] sr_wdata,
    input  logic                cmd_write,
    input  logic [ADDR_W-1:0]   wr_addr,
    output logic                array_grant,
    output logic                array_deny,
    output logic                sr_grant,
    output logic                sr_deny,
    output logic [STATUS_W-1:0] status
);
    typedef struct packed {
        logic grant;
        logic deny;
    } arr_st_t;

    logic         wel;
    logic         fenced;
    logic         sr_waiting;
    prot_fields_t fields;
    arr_st_t      arr_d, arr_q;

    bwp_wel u_wel (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (cmd_wren),
        .clr_i  (cmd_wrdi),
        .done_i (wr_done),
        .wel_o  (wel)
    );

    bwp_srw #(.DATA_W(STATUS_W)) u_srw (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_i     (cmd_wrsr),
        .data_i    (sr_wdata),
        .cs_n      (cs_n),
        .wp_n      (wp_n),
        .busy      (busy),
        .wel       (wel),
        .fields_o  (fields),
        .grant_o   (sr_grant),
        .deny_o    (sr_deny),
        .waiting_o (sr_waiting)
    );

    bwp_range #(.ADDR_W(ADDR_W)) u_range (
        .fence (fields.fence),
        .addr  (wr_addr),
        .hit   (fenced)
    );

    always_comb begin
        arr_d = '0;
        if (cmd_write) begin
            if (busy || !wel || fenced || sr_waiting) begin
                arr_d.deny = 1'b1;
            end else begin
                arr_d.grant = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arr_q <= '0;
        end else begin
            arr_q <= arr_d;
        end
    end

    assign array_grant = arr_q.grant;
    assign array_deny  = arr_q.deny;

    always_comb begin
        status                      = '0;
        status[BIT_LOCK]            = fields.lock_en;
        status[BIT_BP_HI:BIT_BP_LO] = fields.fence;
        status[BIT_WEL]             = wel;
        status[BIT_BUSY]            = busy;
    end
endmodule

// File: rtl/bwp_ctrl_chk.sv
module bwp_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       wp_n,
    input logic       busy,
    input logic       cmd_wrsr,
    input logic       cmd_write,
    input logic       array_grant,
    input logic       array_deny,
    input logic       sr_grant,
    input logic       sr_deny,
    input logic [7:0] status
);
    AST_ARRAY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(array_grant && array_deny)); // R9

    AST_ARRAY_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_write |=> (array_grant || array_deny)); // R9

    AST_NO_WEL_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_write && !status[1]) |=> array_deny); // R2

    AST_FULL_FENCE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_write && status[3:2] == 2'b11) |=> array_deny); // R1

    AST_BUSY_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_write && busy) |=> array_deny); // R7

    AST_SR_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        sr_grant |-> $past(cs_n)); // R3

    AST_PIN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wrsr && status[7] && !wp_n) |=> sr_deny); // R4

    AST_DENY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        sr_deny |-> $stable(status[7:2])); // R5

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        status[6:4] == 3'b000); // R8
endmodule

bind bwp_ctrl bwp_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .wp_n        (wp_n),
    .busy        (busy),
    .cmd_wrsr    (cmd_wrsr),
    .cmd_write   (cmd_write),
    .array_grant (array_grant),
    .array_deny  (array_deny),
    .sr_grant    (sr_grant),
    .sr_deny     (sr_deny),
    .status      (status)
);

// File: tb/bwp_ctrl_tb.sv
module bwp_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, wp_n = 1'b1, busy = 1'b0, wr_done = 1'b0;
    logic cmd_wren = 1'b0, cmd_wrdi = 1'b0, cmd_wrsr = 1'b0, cmd_write = 1'b0;
    logic [7:0] sr_wdata = '0;
    logic [AW-1:0] wr_addr = '0;
    logic array_grant, array_deny, sr_grant, sr_deny;
    logic [7:0] status;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bwp_ctrl #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .busy(busy),
        .wr_done(wr_done), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
        .cmd_wrsr(cmd_wrsr), .sr_wdata(sr_wdata), .cmd_write(cmd_write),
        .wr_addr(wr_addr), .array_grant(array_grant), .array_deny(array_deny),
        .sr_grant(sr_grant), .sr_deny(sr_deny), .status(status)
    );

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wren();
        cmd_wren = 1'b1; @(negedge clk); cmd_wren = 1'b0;
    endtask

    task automatic done_pulse();
        wr_done = 1'b1; @(negedge clk); wr_done = 1'b0;
    endtask

    // drive an array write, check the pulse pair one edge later
    task automatic arr_try(input logic [AW-1:0] a, input logic exp_ok, input string req);
        cmd_write = 1'b1; wr_addr = a; @(negedge clk); cmd_write = 1'b0;
        chk({14'd0, array_grant, array_deny}, {14'd0, exp_ok, ~exp_ok}, req);
    endtask

    // full status write with CS rise; expects grant
    task automatic sr_commit(input logic [7:0] d, input logic [7:0] exp_st, input string req);
        wren();
        cs_n = 1'b0; cmd_wrsr = 1'b1; sr_wdata = d; @(negedge clk); cmd_wrsr = 1'b0;
        chk({14'd0, sr_grant, sr_deny}, 16'h0, {req, " waiting"});
        cs_n = 1'b1; @(negedge clk);
        chk({14'd0, sr_grant, sr_deny}, 16'h2, {req, " grant"});
        chk({8'd0, status}, {8'd0, exp_st}, {req, " status"});
        done_pulse();
    endtask

    task automatic t_reset();
        chk({8'd0, status}, 16'h0, "R8 reset status");
        chk({12'd0, array_grant, array_deny, sr_grant, sr_deny}, 16'h0, "R8 reset pulses");
    endtask

    task automatic t_wel();
        arr_try(14'h0010, 1'b0, "R2 no latch denies");
        wren();
        chk({8'd0, status}, 16'h02, "R2 latch set bit1");
        arr_try(14'h3FFF, 1'b1, "R1 no fence top addr");
        cmd_wrdi = 1'b1; @(negedge clk); cmd_wrdi = 1'b0;
        chk({8'd0, status}, 16'h00, "R2 disable clears");
        arr_try(14'h0000, 1'b0, "R2 after disable");
    endtask

    task automatic t_busy();
        wren();
        busy = 1'b1; #1;
        chk({8'd0, status}, 16'h03, "R7 busy bit0");
        arr_try(14'h0001, 1'b0, "R7 busy array");
        cs_n = 1'b0; cmd_wrsr = 1'b1; sr_wdata = 8'h0C; @(negedge clk); cmd_wrsr = 1'b0;
        chk({14'd0, sr_grant, sr_deny}, 16'h1, "R7 busy status write");
        cs_n = 1'b1; busy = 1'b0; @(negedge clk);
        chk({8'd0, status}, 16'h02, "R7 status unchanged");
        done_pulse();
        chk({8'd0, status}, 16'h00, "R7 done clears latch");
    endtask

    task automatic t_fences();
        sr_commit(8'h04, 8'h06, "R3 fence quarter");
        wren();
        arr_try(14'h2FFF, 1'b1, "R1 quarter below");
        wren();
        arr_try(14'h3000, 1'b0, "R1 quarter edge");
        sr_commit(8'h08, 8'h0A, "R3 fence half");
        wren();
        arr_try(14'h1FFF, 1'b1, "R1 half below");
        wren();
        arr_try(14'h2000, 1'b0, "R1 half edge");
        sr_commit(8'h0C, 8'h0E, "R3 fence all");
        wren();
        arr_try(14'h0000, 1'b0, "R1 all zero addr");
        sr_commit(8'h00, 8'h02, "R3 fence none");
        done_pulse();
    endtask

    task automatic t_pin();
        sr_commit(8'h80, 8'h82, "R3 lock enable");
        // R4: pin low at strobe
        wp_n = 1'b0; wren();
        cs_n = 1'b0; cmd_wrsr = 1'b1; sr_wdata = 8'h0C; @(negedge clk); cmd_wrsr = 1'b0;
        chk({14'd0, sr_grant, sr_deny}, 16'h1, "R4 pin lock deny");
        chk({8'd0, status}, 16'h82, "R4 status kept");
        cs_n = 1'b1; wp_n = 1'b1; @(negedge clk);
        // R5: pin falls while waiting
        cs_n = 1'b0; cmd_wrsr = 1'b1; sr_wdata = 8'h84; @(negedge clk); cmd_wrsr = 1'b0;
        chk({14'd0, sr_grant, sr_deny}, 16'h0, "R5 accepted waiting");
        wp_n = 1'b0; @(negedge clk);
        chk({14'd0, sr_grant, sr_deny}, 16'h1, "R5 cancel on pin drop");
        chk({8'd0, status}, 16'h82, "R5 status kept");
        cs_n = 1'b1; wp_n = 1'b1; @(negedge clk);
        // R5: pin falls together with CS rise: already committed
        cs_n = 1'b0; cmd_wrsr = 1'b1; sr_wdata = 8'h88; @(negedge clk); cmd_wrsr = 1'b0;
        cs_n = 1'b1; wp_n = 1'b0; @(negedge clk);
        chk({14'd0, sr_grant, sr_deny}, 16'h2, "R5 pin after CS ignored");
        chk({8'd0, status}, 16'h8A, "R5 committed status");
        done_pulse();
        // clear lock with pin high
        wp_n = 1'b1;
        sr_commit(8'h00, 8'h02, "R6 unlock");
        // R6: lock off, pin low, write allowed
        wp_n = 1'b0;
        sr_commit(8'h0C, 8'h0E, "R6 pin ignored");
        chk({8'd0, status}, 16'h0C, "R6 after done");
        wp_n = 1'b1;
        sr_commit(8'hFF, 8'h8E, "R8 reserved bits");
        chk({8'd0, status}, 16'h8C, "R8 reserved zero");
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_wel();
                t_busy();
                t_fences();
                t_pin();
            end
            begin
                repeat (5000) @(negedge clk);
                errors++;
                $display("FAIL watchdog expired actual=0x0 expected=0x1");
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule